// File: doc/BRIEF.md
# Burst Memory Address Sequencer

This block produces the word address presented to a synchronous burst memory on every clock cycle. A starting address is captured from the external address bus when one of two active-low address strobes is sampled low at a rising clock edge. One strobe belongs to the processor side and is honoured only while the primary chip enable is asserted. The other belongs to the memory controller and always loads. After a load, a two-bit burst offset is generated internally. It steps by one on each edge where the active-low advance input is low, so a burst covers four word addresses and then repeats.

The low two bits of the output address follow either a linear order or an interleaved order. In linear order they are the start bits plus the offset, modulo four. In interleaved order they are the start bits XOR the offset. The order select input is not registered, so a change on it reaches the output address within the same cycle. The upper address bits come from the captured start address and are never altered by the burst offset. A synchronous active-high reset clears the address and the offset.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) leaves addr_out at zero and burst_pos at zero, and it overrides any strobe active in that cycle.
- R2: When strobe_c_n is low at a rising edge, addr_out equals the sampled addr_in after that edge and burst_pos is 0, whatever the level of chip_en_n.
- R3: strobe_p_n low loads addr_in only when chip_en_n is also low. With chip_en_n high it is ignored, and the sequencer advances or holds as if the strobe were high.
- R4: With no load active, adv_n low at a rising edge increments burst_pos by one modulo 4 (3 is followed by 0).
- R5: With no load and adv_n high, addr_out and burst_pos keep their values across the edge.
- R6: When a load and adv_n low coincide, the load wins: addr_out takes addr_in and burst_pos becomes 0.
- R7: With interleave low (linear order), addr_out[1:0] equals (start[1:0] + burst_pos) mod 4.
- R8: With interleave high (interleaved order), addr_out[1:0] equals start[1:0] XOR burst_pos.
- R9: addr_out bits above bit 1 change only on a load and never carry or borrow from the burst offset.
- R10: interleave is asynchronous: a change on it changes addr_out[1:0] without a clock edge, and it leaves burst_pos and the upper bits untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External start address |
| strobe_p_n | input | 1 | Processor-side address strobe, active low, gated by chip_en_n |
| strobe_c_n | input | 1 | Controller-side address strobe, active low, ungated |
| chip_en_n | input | 1 | Primary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | Order select: 1 interleaved, 0 linear (asynchronous) |
| addr_out | output | ADDR_W | Current word address |
| burst_pos | output | 2 | Number of advances since the last load, modulo 4 |

## Verification
A load and an advance can fall in the same cycle, and that case decides whether a new burst starts cleanly. The bench drives a strobe together with adv_n low in both linear and interleaved order, through both strobes, and also with the processor strobe blocked by chip_en_n. The result is judged after the edge: a load must show addr_in with burst_pos 0, and a blocked load must show only the advanced offset on the old start address.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int BURST_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bsq_strobe_gate.sv
module bsq_strobe_gate (
  input  logic strobe_p_n,
  input  logic strobe_c_n,
  input  logic chip_en_n,
  input  logic adv_n,
  output logic load,
  output logic step
);
  logic p_load;
  logic c_load;

  always_comb begin
    p_load = ~strobe_p_n & ~chip_en_n;
    c_load = ~strobe_c_n;
    load   = p_load | c_load;
    step   = ~adv_n & ~load;
  end
endmodule

// File: rtl/bsq_burst_cnt.sv
module bsq_burst_cnt #(
  parameter int CNT_W = bsq_pkg::BURST_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= '0;
    else if (step)
      cnt <= cnt + ONE;
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == '0)); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> (cnt == CNT_W'($past(cnt) + ONE))); // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt)); // R5
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst)
      base <= '0;
    else if (load)
      base <= addr_in;
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(base)); // R9
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map #(
  parameter int CNT_W = bsq_pkg::BURST_W
) (
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] cnt,
  input  bsq_pkg::order_e  order,
  output logic [CNT_W-1:0] lo
);
  logic [CNT_W-1:0] lin_lo;
  logic [CNT_W-1:0] xor_lo;

  always_comb lin_lo = start_lo + cnt;

  for (genvar b = 0; b < CNT_W; b++) begin : g_xor
    assign xor_lo[b] = start_lo[b] ^ cnt[b];
  end

  always_comb begin
    if (order == bsq_pkg::ORD_INTERLEAVE)
      lo = xor_lo;
    else
      lo = lin_lo;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        burst_pos
);
  localparam int CNT_W = bsq_pkg::BURST_W;

  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lo;
  bsq_pkg::order_e   order;

  always_comb order = bsq_pkg::order_e'(interleave);

  bsq_strobe_gate u_gate (
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .chip_en_n  (chip_en_n),
    .adv_n      (adv_n),
    .load       (load),
    .step       (step)
  );

  bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .addr_in (addr_in),
    .base    (base)
  );

  bsq_burst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .step (step),
    .cnt  (cnt)
  );

  bsq_order_map #(.CNT_W(CNT_W)) u_map (
    .start_lo (base[CNT_W-1:0]),
    .cnt      (cnt),
    .order    (order),
    .lo       (lo)
  );

  always_comb begin
    addr_out  = {base[ADDR_W-1:CNT_W], lo};
    burst_pos = cnt;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && burst_pos == 2'd0)); // R1
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
    !strobe_c_n |=> (addr_out == $past(addr_in) && burst_pos == 2'd0)); // R2
  AST_PROC_GATED: assert property (@(posedge clk) disable iff (rst)
    (strobe_c_n && chip_en_n && adv_n) |=>
      ($stable(burst_pos) && $stable(addr_out[ADDR_W-1:CNT_W]))); // R3
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (strobe_c_n && (strobe_p_n || chip_en_n)) |=>
      $stable(addr_out[ADDR_W-1:CNT_W])); // R9
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int PERIOD = 10;
  localparam int AW     = 18;
  localparam int NV     = 18;
  localparam int VW     = 5 + AW + AW + 2;

  // {strobe_p_n, strobe_c_n, chip_en_n, adv_n, interleave, addr_in, exp_addr, exp_pos}
  localparam logic [VW-1:0] VEC [NV] = '{
    {5'b10110, 18'h12345, 18'h12345, 2'd0}, // R2 controller load, chip enable off
    {5'b11100, 18'h00000, 18'h12346, 2'd1}, // R7 linear step
    {5'b11100, 18'h00000, 18'h12347, 2'd2}, // R4
    {5'b11100, 18'h00000, 18'h12344, 2'd3}, // R7 low bits wrap
    {5'b11100, 18'h00000, 18'h12345, 2'd0}, // R4 count wraps
    {5'b11110, 18'h3FFFF, 18'h12345, 2'd0}, // R5 hold
    {5'b01110, 18'h3FFFF, 18'h12345, 2'd0}, // R3 blocked strobe
    {5'b01011, 18'h2AAA6, 18'h2AAA6, 2'd0}, // R3 enabled strobe
    {5'b11101, 18'h00000, 18'h2AAA7, 2'd1}, // R8
    {5'b11101, 18'h00000, 18'h2AAA4, 2'd2}, // R8
    {5'b11101, 18'h00000, 18'h2AAA5, 2'd3}, // R8
    {5'b01001, 18'h00003, 18'h00003, 2'd0}, // R6 load beats advance
    {5'b11101, 18'h00000, 18'h00002, 2'd1}, // R8
    {5'b10100, 18'h15550, 18'h15550, 2'd0}, // R6 controller load with advance
    {5'b01100, 18'h3FFFF, 18'h15551, 2'd1}, // R3 blocked strobe, advance proceeds
    {5'b11110, 18'h3FFFF, 18'h15551, 2'd1}, // R5
    {5'b10110, 18'h0FFFF, 18'h0FFFF, 2'd0}, // R2
    {5'b11100, 18'h00000, 18'h0FFFC, 2'd1}  // R9 no carry into upper bits
  };
  localparam logic [23:0] TAG [NV] = '{
    "R2 ", "R7 ", "R4 ", "R7 ", "R4 ", "R5 ", "R3 ", "R3 ", "R8 ",
    "R8 ", "R8 ", "R6 ", "R8 ", "R6 ", "R3 ", "R5 ", "R2 ", "R9 "
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_in;
  logic          strobe_p_n, strobe_c_n, chip_en_n, adv_n, interleave;
  logic [AW-1:0] addr_out;
  logic [1:0]    burst_pos;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk        (clk),
    .rst        (rst),
    .addr_in    (addr_in),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .chip_en_n  (chip_en_n),
    .adv_n      (adv_n),
    .interleave (interleave),
    .addr_out   (addr_out),
    .burst_pos  (burst_pos)
  );

  task automatic check(input string req, input logic [AW-1:0] exp_a,
                       input logic [1:0] exp_p);
    checks++;
    if (addr_out !== exp_a) begin
      fails++;
      $display("FAIL %s addr_out actual %h expected %h", req, addr_out, exp_a);
    end
    checks++;
    if (burst_pos !== exp_p) begin
      fails++;
      $display("FAIL %s burst_pos actual %0d expected %0d", req, burst_pos, exp_p);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 5000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; addr_in = '0; strobe_p_n = 1'b1; strobe_c_n = 1'b1;
    chip_en_n = 1'b1; adv_n = 1'b1; interleave = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R1", '0, 2'd0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {strobe_p_n, strobe_c_n, chip_en_n, adv_n, interleave} = VEC[i][VW-1 -: 5];
      addr_in = VEC[i][AW+AW+1 -: AW];
      @(posedge clk);
      #1 check(string'(TAG[i]), VEC[i][AW+1 -: AW], VEC[i][1:0]);
    end

    // R10: order select acts without a clock edge (start low bits 3, pos 1)
    @(negedge clk);
    strobe_p_n = 1'b1; strobe_c_n = 1'b1; adv_n = 1'b1; interleave = 1'b1;
    #1 check("R10", 18'h0FFFE, 2'd1);
    interleave = 1'b0;
    #1 check("R10", 18'h0FFFC, 2'd1);

    // R1: reset mid-burst overrides a controller strobe in the same cycle
    @(negedge clk);
    rst = 1'b1; strobe_c_n = 1'b0; addr_in = 18'h2BCDE; adv_n = 1'b0;
    @(posedge clk);
    #1 check("R1", '0, 2'd0);
    @(negedge clk);
    rst = 1'b0; strobe_c_n = 1'b1; adv_n = 1'b1;

    // R3: enabled processor strobe while controller strobe also low
    @(negedge clk);
    strobe_p_n = 1'b0; strobe_c_n = 1'b0; chip_en_n = 1'b0; addr_in = 18'h00011;
    @(posedge clk);
    #1 check("R3", 18'h00011, 2'd0);
    @(negedge clk);
    strobe_p_n = 1'b1; strobe_c_n = 1'b1; chip_en_n = 1'b1;

    finish_run();
  end
endmodule